// File: doc/BRIEF.md
# Three-Level Loop Schedule Generator

This block walks a nest of three counting loops (inner, middle, outer) and produces, for every element of the nest, a linear element index and a 4-bit condition field. The condition field marks which loops finish on that element, so software or a downstream sequencer can branch on the end of any single loop. Each loop has its own extent, given as the count minus one, so a dimension of size one is legal.

A command port accepts single requests. A query returns the current element without moving. A step returns the current element and then advances the innermost loop. When a loop passes its last value it wraps to zero and carries into the next loop out. A walk command restarts the nest at its first element and streams every element in order, one per accepted transfer, on a valid/ready output that holds its contents while the consumer stalls. A load strobe captures new extents and returns all loops to zero.

Top module: `loop_sched_gen`

## Requirements
- R1: After a synchronous reset or a load, `o_valid` is 0, `cmd_ready` is 1 and all loop counters are zero, so the next query returns index 0.
- R2: A command with `cmd_op` 0 or 3 (query) emits the current index and flags and leaves the state unchanged; a second query returns the same element.
- R3: A command with `cmd_op` 1 (step) emits the current element, then advances, so successive steps emit x + y*(X+1) + z*(X+1)*(Y+1) in increasing order, where X, Y are the inner and middle extents minus one.
- R4: The inner counter counts 0..X; on a step at X it wraps to 0 and carries one step into the middle loop; the middle loop carries into the outer loop the same way.
- R5: Flag bit 0 is set when the inner counter is at its limit; bit 1 when inner and middle are at their limits; bit 2 when all three are at their limits; bit 3 only on the very last element of the schedule.
- R6: A step taken on the last element returns every counter and the index to zero.
- R7: A command with `cmd_op` 2 (walk) restarts at element 0 and emits every element of the schedule in order, ending after the last one with the state back at zero and `cmd_ready` high again.
- R8: While `o_valid` is 1 and `o_ready` is 0, `o_valid`, `o_index` and `o_flags` hold their values.
- R9: `cmd_ready` is 0 while a walk is in progress or the output is stalled; a command presented while `cmd_ready` is 0 is ignored.
- R10: An extent of 0 in every loop gives a one-element schedule whose element has index 0 and all four flag bits set.
- R11: A load during a walk ends the walk and discards the pending output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture extents, clear counters, abort walk |
| ext_x | input | DIM_W | Inner loop count minus one |
| ext_y | input | DIM_W | Middle loop count minus one |
| ext_z | input | DIM_W | Outer loop count minus one |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 query, 1 step, 2 walk, 3 query |
| cmd_ready | output | 1 | Command accepted on this cycle when high with cmd_valid |
| o_valid | output | 1 | Output element valid |
| o_ready | input | 1 | Consumer accepts the output element |
| o_index | output | 3*DIM_W | Linear element index |
| o_flags | output | 4 | Loop-end flags, bit 0 inner up to bit 3 last element |

## Verification
The hardest situation to reach is a walk interrupted from outside: a consumer stall in the middle of a burst, a command arriving while the walk owns the counters, and a load landing while an element is still waiting in the output register. The bench drives the ready line with a repeating stall pattern during walks, holds a step command on the port for several cycles while a walk runs and then checks the state is untouched afterwards, and asserts load a few cycles into a second walk before querying the fresh schedule.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
   localparam int LSG_LOOPS  = 3;
   localparam int LSG_FLAG_W = LSG_LOOPS + 1;

   typedef enum logic [1:0] {
      OP_QUERY = 2'd0,
      OP_STEP  = 2'd1,
      OP_WALK  = 2'd2,
      OP_PEEK  = 2'd3
   } lsg_op_e;
endpackage

// File: rtl/lsg_level.sv
module lsg_level #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] lim,
   output logic         at_end
);
   logic [W-1:0] cnt_q;

   assign at_end = (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt_q <= '0;
      else if (adv)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R4: counter stays inside its extent
   a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= lim);
   // R4: advance below the limit counts up by one
   a_r4_count: assert property (@(posedge clk) disable iff (rst)
      (adv && !clr && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R4: advance at the limit wraps to zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      (adv && !clr && at_end) |=> (cnt_q == '0));
endmodule

// File: rtl/lsg_outreg.sv
module lsg_outreg #(
   parameter int IW = 18,
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          flush,
   input  logic          emit,
   input  logic [IW-1:0] d_idx,
   input  logic [FW-1:0] d_flags,
   input  logic          rdy,
   output logic          space,
   output logic          v,
   output logic [IW-1:0] idx,
   output logic [FW-1:0] flags
);
   assign space = !v || rdy;

   always_ff @(posedge clk) begin
      if (rst || flush) v <= 1'b0;
      else if (emit)    v <= 1'b1;
      else if (rdy)     v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         idx   <= '0;
         flags <= '0;
      end else if (emit) begin
         idx   <= d_idx;
         flags <= d_flags;
      end
   end

   // R8: stalled output holds
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (v && !rdy && !flush) |=> (v && $stable(idx) && $stable(flags)));
   // R5: last-element flag only together with every loop-end flag
   a_r5_last_flags: assert property (@(posedge clk) disable iff (rst)
      (v && flags[FW-1]) |-> (&flags[FW-2:0]));
endmodule

// File: rtl/loop_sched_gen.sv
module loop_sched_gen
   import lsg_pkg::*;
#(
   parameter int DIM_W = 6
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         load,
   input  logic [DIM_W-1:0]             ext_x,
   input  logic [DIM_W-1:0]             ext_y,
   input  logic [DIM_W-1:0]             ext_z,
   input  logic                         cmd_valid,
   input  logic [1:0]                   cmd_op,
   output logic                         cmd_ready,
   output logic                         o_valid,
   input  logic                         o_ready,
   output logic [LSG_LOOPS*DIM_W-1:0]   o_index,
   output logic [LSG_FLAG_W-1:0]        o_flags
);
   localparam int IDX_W = LSG_LOOPS * DIM_W;

   if (DIM_W < 1 || DIM_W > 10) begin : g_bad_dim
      $error("loop_sched_gen: DIM_W must lie in 1..10");
   end

   lsg_op_e                 op;
   logic [IDX_W-1:0]        ext_all;
   logic [DIM_W-1:0]        lim_q [LSG_LOOPS];
   logic [LSG_LOOPS-1:0]    lvl_end;
   logic [LSG_LOOPS-1:0]    cum_end;
   logic [LSG_LOOPS-1:0]    adv;
   logic [IDX_W-1:0]        idx_q;
   logic [LSG_FLAG_W-1:0]   cur_flags;
   logic                    walking_q;
   logic                    space;
   logic                    accept, start_walk, emit, advance, clr_all, last;

   assign op      = lsg_op_e'(cmd_op);
   assign ext_all = {ext_z, ext_y, ext_x};

   always_ff @(posedge clk) begin
      for (int i = 0; i < LSG_LOOPS; i++) begin
         if (rst)       lim_q[i] <= '0;
         else if (load) lim_q[i] <= ext_all[i*DIM_W +: DIM_W];
      end
   end

   assign cmd_ready  = !walking_q && space;
   assign accept     = cmd_valid && cmd_ready && !load;
   assign start_walk = accept && (op == OP_WALK);
   assign emit       = !load && ((accept && op != OP_WALK) || (walking_q && space));
   assign advance    = !load && ((accept && op == OP_STEP) || (walking_q && space));
   assign clr_all    = load || start_walk;
   assign last       = cum_end[LSG_LOOPS-1];
   assign adv[0]     = advance;

   for (genvar i = 0; i < LSG_LOOPS; i++) begin : g_lvl
      lsg_level #(.W(DIM_W)) u_lvl (
         .clk    (clk),
         .rst    (rst),
         .clr    (clr_all),
         .adv    (adv[i]),
         .lim    (lim_q[i]),
         .at_end (lvl_end[i])
      );
      if (i == 0) begin : g_first
         assign cum_end[i] = lvl_end[i];
      end else begin : g_outer
         assign cum_end[i] = cum_end[i-1] && lvl_end[i];
      end
      if (i < LSG_LOOPS - 1) begin : g_carry
         assign adv[i+1] = adv[i] && lvl_end[i];
      end
   end

   assign cur_flags = {last, cum_end};

   always_ff @(posedge clk) begin
      if (rst || clr_all) idx_q <= '0;
      else if (advance)   idx_q <= last ? '0 : idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || load)                    walking_q <= 1'b0;
      else if (start_walk)                walking_q <= 1'b1;
      else if (walking_q && space && last) walking_q <= 1'b0;
   end

   lsg_outreg #(.IW(IDX_W), .FW(LSG_FLAG_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .flush   (load),
      .emit    (emit),
      .d_idx   (idx_q),
      .d_flags (cur_flags),
      .rdy     (o_ready),
      .space   (space),
      .v       (o_valid),
      .idx     (o_index),
      .flags   (o_flags)
   );

   // R3: a step below the last element moves the index up by one
   a_r3_step_inc: assert property (@(posedge clk) disable iff (rst)
      (advance && !last && !load) |=> (idx_q == $past(idx_q) + 1'b1));
   // R6: a step on the last element returns the index to zero
   a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (advance && last && !load) |=> (idx_q == '0));
   // R7: an active walk with room in the output produces an element
   a_r7_walk_feeds: assert property (@(posedge clk) disable iff (rst)
      (walking_q && space && !load) |=> o_valid);
   // R11: load discards the pending output
   a_r11_load_clears: assert property (@(posedge clk) disable iff (rst)
      load |=> !o_valid);
endmodule

// File: tb/tb_loop_sched_gen.sv
module tb_loop_sched_gen;
   localparam int DW = 6;
   localparam int IW = 3 * DW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load = 1'b0;
   logic [DW-1:0] ext_x = '0, ext_y = '0, ext_z = '0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic          cmd_ready;
   logic          o_valid;
   logic          o_ready = 1'b1;
   logic [IW-1:0] o_index;
   logic [3:0]    o_flags;

   loop_sched_gen #(.DIM_W(DW)) dut (
      .clk(clk), .rst(rst), .load(load),
      .ext_x(ext_x), .ext_y(ext_y), .ext_z(ext_z),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
      .o_valid(o_valid), .o_ready(o_ready), .o_index(o_index), .o_flags(o_flags)
   );

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [IW+3:0] expq[$];
   int lx, ly, lz, mx, my, mz, mi;
   bit stall = 0, hold_low = 0;
   int cyc = 0;
   string cur_req = "R3";

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] mflags();
      bit e0, e1, e2;
      e0 = (mx == lx);
      e1 = e0 && (my == ly);
      e2 = e1 && (mz == lz);
      return {e2, e2, e1, e0};
   endfunction

   task automatic push_cur();
      logic [IW-1:0] iv;
      iv = IW'(mi);
      expq.push_back({iv, mflags()});
   endtask

   task automatic madv();
      if (mx == lx && my == ly && mz == lz) begin
         mx = 0; my = 0; mz = 0; mi = 0;
      end else begin
         mi++;
         if (mx != lx) mx++;
         else begin
            mx = 0;
            if (my != ly) my++;
            else begin my = 0; mz++; end
         end
      end
   endtask

   // consumer ready pattern
   always @(negedge clk) begin
      cyc++;
      o_ready = hold_low ? 1'b0 : !(stall && (cyc % 3 != 0));
   end

   // monitor: pops the scoreboard on every transfer, checks holds on stalls
   logic          pv = 0, pr = 0;
   logic [IW-1:0] pidx;
   logic [3:0]    pfl;
   always @(negedge clk) begin
      logic [IW+3:0] e;
      #1;
      if (!rst && !load) begin
         if (pv && !pr) begin
            check(o_valid == 1'b1, "R8", "valid held", o_valid, 1);
            check(o_index == pidx, "R8", "index held", o_index, pidx);
            check(o_flags == pfl, "R8", "flags held", o_flags, pfl);
         end
         if (o_valid && o_ready) begin
            if (expq.size() == 0) begin
               check(0, cur_req, "unexpected output index", o_index, -1);
            end else begin
               e = expq.pop_front();
               check(o_index == e[IW+3:4], cur_req, "index", o_index, e[IW+3:4]);
               check(o_flags == e[3:0], "R5", "flags", o_flags, e[3:0]);
            end
         end
         pv = o_valid; pr = o_ready; pidx = o_index; pfl = o_flags;
      end else begin
         pv = 0;
      end
   end

   task automatic do_load(input int x, input int y, input int z);
      @(negedge clk);
      load = 1'b1;
      ext_x = DW'(x); ext_y = DW'(y); ext_z = DW'(z);
      lx = x; ly = y; lz = z;
      mx = 0; my = 0; mz = 0; mi = 0;
      @(posedge clk);
      #1;
      load = 1'b0;
      expq.delete();
      check(o_valid == 1'b0, "R1", "valid after load", o_valid, 0);
   endtask

   task automatic issue(input logic [1:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = op;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      case (op)
         2'd1: begin push_cur(); madv(); end
         2'd2: begin
            mx = 0; my = 0; mz = 0; mi = 0;
            for (int k = 0; k < (lx + 1) * (ly + 1) * (lz + 1); k++) begin
               push_cur(); madv();
            end
         end
         default: push_cur();
      endcase
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         #2;
         if (cmd_ready && !o_valid && expq.size() == 0) break;
      end
      check(expq.size() == 0, req, "pending expected items", expq.size(), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      // R1: reset state
      check(o_valid == 1'b0, "R1", "valid after reset", o_valid, 0);
      check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);

      do_load(2, 1, 2);
      cur_req = "R2";
      issue(2'd0); issue(2'd0); issue(2'd3);
      wait_idle("R2");

      cur_req = "R3";
      for (int k = 0; k < 8; k++) issue(2'd1);   // R4 carries across rows
      issue(2'd0);
      wait_idle("R4");

      cur_req = "R6";
      for (int k = 0; k < 12; k++) issue(2'd1);  // passes the last element
      wait_idle("R6");

      // R7 walk under consumer stalls, R9 commands ignored while walking
      cur_req = "R7";
      stall = 1;
      issue(2'd2);
      check(cmd_ready == 1'b0, "R9", "ready during walk", cmd_ready, 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1;
      for (int k = 0; k < 3; k++) begin
         #1;
         check(cmd_ready == 1'b0, "R9", "ready while step held", cmd_ready, 0);
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      wait_idle("R7");
      stall = 0;
      cur_req = "R9";
      issue(2'd0);                                // state back at element 0
      wait_idle("R9");

      // R8 explicit stall on a single response
      cur_req = "R8";
      hold_low = 1;
      issue(2'd1);
      repeat (4) @(negedge clk);
      #2;
      check(cmd_ready == 1'b0, "R9", "ready while output stalled", cmd_ready, 0);
      hold_low = 0;
      wait_idle("R8");

      // R10 single-element schedule
      do_load(0, 0, 0);
      cur_req = "R10";
      for (int k = 0; k < 3; k++) issue(2'd1);
      issue(2'd2);
      wait_idle("R10");

      // R7 walk without stalls on a different shape
      do_load(3, 2, 1);
      cur_req = "R7";
      issue(2'd1); issue(2'd1);
      issue(2'd2);
      wait_idle("R7");

      // R11 load during a walk
      cur_req = "R11";
      stall = 1;
      issue(2'd2);
      repeat (5) @(negedge clk);
      stall = 0;
      do_load(1, 0, 0);
      check(cmd_ready == 1'b1, "R11", "ready after abort", cmd_ready, 1);
      issue(2'd0); issue(2'd1); issue(2'd1); issue(2'd0);
      wait_idle("R11");

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule